// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block is a first-in first-out queue whose write port and read port run on separate, unrelated clocks. Words enter on the write clock and leave on the read clock. The queue memory is an inferred register array, and its depth and word width are parameters. Each side sees only the status that concerns it. The write side gets a full/input-ready flag and an almost-full flag. The read side gets an empty/output-ready flag and an almost-empty flag. Every flag is registered in the clock domain of the side that reads it.

Two reset inputs are provided. The master reset clears both pointers. While it is held, the block also captures the operating mode and the two almost-flag thresholds from configuration inputs. The partial reset only flushes the stored data. The mode and the thresholds that were captured earlier stay in force.

The block has two operating modes. In standard mode a read request is needed to bring a word onto the output. In fall-through mode the oldest word is presented on the output by itself, and the two status outputs change meaning to output-ready and input-ready. Pointers cross between the clock domains in Gray code, through two flip-flop stages in the receiving domain.

Top module: `dual_clk_fifo`

## Requirements
- R1: After master reset the block is empty. rdData is 0 and almostEmpty is 1. almostFull is 0. In standard mode emptyOr is 1 and fullIr is 0. In fall-through mode emptyOr is 0 and fullIr is 1.
- R2: The mode (cfgFwft: 1 selects fall-through) and the offsets cfgAeOff and cfgAfOff are captured while mrstN is low. These inputs are ignored at all other times, and the captured values hold until the next master reset.
- R3: A low pulse on prstN empties the queue, which then behaves as in R1. The mode and both offsets captured at the last master reset remain in force.
- R4: In standard mode a written word stays in memory, and rdData changes only on an accepted read. A read is accepted when rdEn is 1 and emptyOr is 0 at a read-clock edge. The word is on rdData just after that edge.
- R5: In fall-through mode the oldest word appears on rdData and emptyOr rises without any read. The output holds that word until rdEn is 1 at a read-clock edge while emptyOr is 1. That edge then brings the next word, or clears emptyOr.
- R6: Flag meanings in standard mode: emptyOr=1 means empty and fullIr=1 means full. In fall-through mode: emptyOr=1 means valid data is on rdData, and fullIr=1 means there is room for a write.
- R7: A write while the memory is full and a read that is not accepted are both ignored. Neither moves a pointer or changes the stored data.
- R8: almostEmpty is 1 when the number of stored words is less than or equal to the captured cfgAeOff. In fall-through mode the word held on the output counts as stored.
- R9: almostFull is 1 when the number of free memory words is less than or equal to the captured cfgAfOff.
- R10: Words are read in the order they were written. The memory holds exactly DEPTH words. In fall-through mode DEPTH+1 words can be held: the memory plus the output register.
- R11: A write into an empty queue clears emptyOr at the third read-clock edge after the write edge in standard mode. In fall-through mode, emptyOr rises at the fourth read-clock edge after the write edge. A read from a full memory clears fullIr at the third write-clock edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Master reset, active low, asserts asynchronously |
| prstN | input | 1 | Partial reset (flush), active low |
| cfgFwft | input | 1 | Mode select, captured during master reset |
| cfgAeOff | input | $clog2(DEPTH)+1 | Almost-empty threshold, captured during master reset |
| cfgAfOff | input | $clog2(DEPTH)+1 | Almost-full threshold, captured during master reset |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Write word |
| fullIr | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| almostFull | output | 1 | Free space at or below the threshold |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Read word |
| emptyOr | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |
| almostEmpty | output | 1 | Fill level at or below the threshold |

## Verification
Each result has a fixed due time. In standard mode a read's data is due just after the accepted read-clock edge. In fall-through mode the data is already on rdData when the read is accepted. After a write into an empty queue, the empty flag clears at the third read-clock edge, and output-ready rises at the fourth. After a read from a full memory, fullIr clears at the third write-clock edge. The bench drives inputs half a nanosecond after an edge and samples at falling edges. Its monitors therefore judge each acceptance from the flag value that the next rising edge will see. The latency checks count edges explicitly: the flag must still be in its old state one edge before the due edge, and in its new state right after it. The level checks on the almost flags are made only after both clock domains have settled.

// File: rtl/xq_pkg.sv
`timescale 1ns/1ps
package xq_pkg;

  // Strobes issued by the control to the datapath, one per clock domain.
  typedef struct packed {
    logic wrPush;   // write-clock domain: store wrData at wrAddr
    logic rdPop;    // read-clock domain: load rdData from rdAddr
  } xqStrobes_t;

endpackage

// File: rtl/xq_sync.sv
`timescale 1ns/1ps
module xq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/xq_ctrl.sv
`timescale 1ns/1ps
module xq_ctrl import xq_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          flushN,
  input  logic          cfgFwft,
  input  logic [PW-1:0] cfgAeOff,
  input  logic [PW-1:0] cfgAfOff,
  input  logic          wrEn,
  input  logic          rdEn,
  output xqStrobes_t    stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullIr,
  output logic          almostFull,
  output logic          emptyOr,
  output logic          almostEmpty,
  output logic          fwftW,
  output logic          fwftR,
  output logic          memFullW,
  output logic          memEmptyR
);

  localparam int CW = PW + 1;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write-clock domain ----------------
  logic [PW-1:0] afOffW;
  logic [PW-1:0] wrPtr, wrPtrNext, wrGray, wrGrayNext;
  logic [PW-1:0] rdGrayW, rdBinW, usedW, freeW;
  logic          wrPush, fullNext, afNext, afQ;

  // configuration: captured on every write edge while master reset is held
  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      fwftW  <= cfgFwft;
      afOffW <= cfgAfOff;
    end
  end

  xq_sync #(.W(PW), .STAGES(2)) rdPtrSync_i (
    .clk(wrClk), .rstN(flushN), .d(rdGrayOut), .q(rdGrayW)
  );

  assign wrPush     = wrEn & ~memFullW;
  assign wrPtrNext  = wrPtr + PW'(wrPush);
  assign wrGrayNext = wrPtrNext ^ (wrPtrNext >> 1);
  assign rdBinW     = grayToBin(rdGrayW);
  assign usedW      = wrPtrNext - rdBinW;
  assign freeW      = PW'(DEPTH) - usedW;
  assign fullNext   = (wrGrayNext == {~rdGrayW[PW-1:PW-2], rdGrayW[PW-3:0]});
  assign afNext     = (freeW <= afOffW);

  always_ff @(posedge wrClk or negedge flushN) begin
    if (!flushN) begin
      wrPtr    <= '0;
      wrGray   <= '0;
      memFullW <= 1'b0;
      afQ      <= 1'b0;
    end else begin
      wrPtr    <= wrPtrNext;
      wrGray   <= wrGrayNext;
      memFullW <= fullNext;
      afQ      <= afNext;
    end
  end

  // ---------------- read-clock domain ----------------
  logic [PW-1:0] aeOffR;
  logic [PW-1:0] rdPtr, rdPtrNext, rdGrayOut, rdGrayNext;
  logic [PW-1:0] wrGrayR, wrBinR;
  logic [CW-1:0] cntNext;
  logic          rdPop, outValid, outValidNext, emptyNext, aeNext, aeQ;

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      fwftR  <= cfgFwft;
      aeOffR <= cfgAeOff;
    end
  end

  xq_sync #(.W(PW), .STAGES(2)) wrPtrSync_i (
    .clk(rdClk), .rstN(flushN), .d(wrGray), .q(wrGrayR)
  );

  always_comb begin
    if (fwftR) begin
      rdPop        = (~outValid | rdEn) & ~memEmptyR;
      outValidNext = rdPop | (outValid & ~rdEn);
    end else begin
      rdPop        = rdEn & ~memEmptyR;
      outValidNext = 1'b0;
    end
  end

  assign rdPtrNext  = rdPtr + PW'(rdPop);
  assign rdGrayNext = rdPtrNext ^ (rdPtrNext >> 1);
  assign wrBinR     = grayToBin(wrGrayR);
  assign emptyNext  = (rdGrayNext == wrGrayR);
  assign cntNext    = {1'b0, wrBinR - rdPtrNext} + CW'(outValidNext);
  assign aeNext     = (cntNext <= {1'b0, aeOffR});

  always_ff @(posedge rdClk or negedge flushN) begin
    if (!flushN) begin
      rdPtr     <= '0;
      rdGrayOut <= '0;
      memEmptyR <= 1'b1;
      outValid  <= 1'b0;
      aeQ       <= 1'b1;
    end else begin
      rdPtr     <= rdPtrNext;
      rdGrayOut <= rdGrayNext;
      memEmptyR <= emptyNext;
      outValid  <= outValidNext;
      aeQ       <= aeNext;
    end
  end

  // ---------------- outputs ----------------
  assign stb.wrPush  = wrPush;
  assign stb.rdPop   = rdPop;
  assign wrAddr      = wrPtr[AW-1:0];
  assign rdAddr      = rdPtr[AW-1:0];
  assign fullIr      = fwftW ? ~memFullW : memFullW;
  assign almostFull  = afQ;
  assign emptyOr     = fwftR ? outValid : memEmptyR;
  assign almostEmpty = aeQ;

endmodule

// File: rtl/xq_dpath.sv
`timescale 1ns/1ps
module xq_dpath import xq_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             flushN,
  input  xqStrobes_t       stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrPush) mem[wrAddr] <= wrData;
  end

  // Output register: filled on a pop in both modes.
  always_ff @(posedge rdClk or negedge flushN) begin
    if (!flushN)        rdData <= '0;
    else if (stb.rdPop) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo import xq_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             cfgFwft,
  input  logic [PW-1:0]    cfgAeOff,
  input  logic [PW-1:0]    cfgAfOff,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             fullIr,
  output logic             almostFull,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             emptyOr,
  output logic             almostEmpty
);

  logic          flushN;
  xqStrobes_t    stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftW, fwftR, memFullW, memEmptyR;

  assign flushN = mrstN & prstN;

  xq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .flushN(flushN),
    .cfgFwft(cfgFwft), .cfgAeOff(cfgAeOff), .cfgAfOff(cfgAfOff),
    .wrEn(wrEn), .rdEn(rdEn), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullIr(fullIr), .almostFull(almostFull), .emptyOr(emptyOr),
    .almostEmpty(almostEmpty), .fwftW(fwftW), .fwftR(fwftR),
    .memFullW(memFullW), .memEmptyR(memEmptyR)
  );

  xq_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .flushN(flushN), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/xq_checker.sv
`timescale 1ns/1ps
module xq_checker #(
  parameter int WIDTH = 36
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             mrstN,
  input logic             flushN,
  input logic             rdEn,
  input logic             emptyOr,
  input logic [WIDTH-1:0] rdData,
  input logic             wrPush,
  input logic             rdPop,
  input logic             fwftW,
  input logic             fwftR,
  input logic             memFullW,
  input logic             memEmptyR
);

  // R7: the memory only becomes full as the result of an accepted write
  p_full_from_push_r7: assert property (@(posedge wrClk) disable iff (!flushN)
    $rose(memFullW) |-> $past(wrPush));

  // R7: the memory only becomes empty as the result of a pop
  p_empty_from_pop_r7: assert property (@(posedge rdClk) disable iff (!flushN)
    $rose(memEmptyR) |-> $past(rdPop));

  // R4: in standard mode the output word moves only on a read request
  p_std_hold_r4: assert property (@(posedge rdClk) disable iff (!flushN)
    (!fwftR && !rdEn) |=> $stable(rdData));

  // R5: in fall-through mode a presented word waits for its read
  p_fwft_hold_r5: assert property (@(posedge rdClk) disable iff (!flushN)
    (fwftR && emptyOr && !rdEn) |=> (emptyOr && $stable(rdData)));

  // R2/R3: the mode stays fixed outside master reset
  p_mode_kept_rd_r3: assert property (@(posedge rdClk) disable iff (!mrstN)
    $stable(fwftR));
  p_mode_kept_wr_r2: assert property (@(posedge wrClk) disable iff (!mrstN)
    $stable(fwftW));

endmodule

bind dual_clk_fifo xq_checker #(.WIDTH(WIDTH)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .flushN(flushN),
  .rdEn(rdEn), .emptyOr(emptyOr), .rdData(rdData),
  .wrPush(stb.wrPush), .rdPop(stb.rdPop),
  .fwftW(fwftW), .fwftR(fwftR), .memFullW(memFullW), .memEmptyR(memEmptyR)
);

// File: tb/dual_clk_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clk_fifo_tb_top;

  localparam int DEPTH = 16;
  localparam int WIDTH = 36;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic             wrClk = 1'b0, rdClk = 1'b0;
  logic             mrstN = 1'b0, prstN = 1'b1;
  logic             cfgFwft = 1'b0;
  logic [PW-1:0]    cfgAeOff = '0, cfgAfOff = '0;
  logic             wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic             fullIr, almostFull, emptyOr, almostEmpty;
  logic [WIDTH-1:0] rdData;

  always #2 wrClk = ~wrClk;   // 250 MHz write clock
  always #3 rdClk = ~rdClk;   // unrelated read clock

  dual_clk_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .cfgFwft(cfgFwft), .cfgAeOff(cfgAeOff), .cfgAfOff(cfgAfOff),
    .wrEn(wrEn), .wrData(wrData), .fullIr(fullIr), .almostFull(almostFull),
    .rdEn(rdEn), .rdData(rdData), .emptyOr(emptyOr), .almostEmpty(almostEmpty)
  );

  int  nChecks = 0, nFails = 0;
  int  seed = 1;
  int  pushCount = 0;
  bit  benchFwft = 1'b0;
  bit  pendStd = 1'b0;
  logic [WIDTH-1:0] expQ [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmpHead(input logic [WIDTH-1:0] act, input string req);
    logic [WIDTH-1:0] e;
    if (expQ.size() == 0) begin
      check(1'b0, req, "read with nothing expected", 64'(act), 64'hx);
    end else begin
      e = expQ.pop_front();
      check(act === e, req, "read data order (R10)", 64'(act), 64'(e));
    end
  endtask

  // write monitor: an item is pushed when the coming edge accepts it
  always @(negedge wrClk) begin
    if (mrstN && prstN && wrEn && (benchFwft ? fullIr : !fullIr)) begin
      expQ.push_back(wrData);
      pushCount++;
    end
  end

  // read monitor: compares accepted reads against the scoreboard
  always @(negedge rdClk) begin
    if (pendStd) begin
      cmpHead(rdData, "R4");
      pendStd = 1'b0;
    end
    if (mrstN && prstN && rdEn && (benchFwft ? emptyOr : !emptyOr)) begin
      if (benchFwft) cmpHead(rdData, "R5");
      else           pendStd = 1'b1;
    end
  end

  function automatic logic [WIDTH-1:0] mkWord(input int s);
    return {4'hC, 16'(s * 16'd251), 16'(s ^ 16'h5A5A)};
  endfunction

  task automatic writeWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wrClk); #0.5;
      wrEn = 1'b1; wrData = mkWord(seed); seed++;
    end
    @(posedge wrClk); #0.5;
    wrEn = 1'b0;
  endtask

  task automatic readWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge rdClk); #0.5;
      rdEn = 1'b1;
    end
    @(posedge rdClk); #0.5;
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(posedge rdClk);
    @(negedge rdClk);
  endtask

  task automatic mreset(input bit f, input int ae, input int af);
    @(negedge wrClk); #0.5;
    mrstN = 1'b0; cfgFwft = f; cfgAeOff = PW'(ae); cfgAfOff = PW'(af);
    repeat (4) @(posedge wrClk);
    repeat (3) @(posedge rdClk);
    @(negedge wrClk); #0.5;
    benchFwft = f; expQ.delete(); pendStd = 1'b0; pushCount = 0;
    mrstN = 1'b1;
    // configuration inputs change afterwards and must be ignored (R2)
    cfgFwft = ~f; cfgAeOff = PW'(DEPTH); cfgAfOff = PW'(DEPTH);
    settle();
  endtask

  task automatic preset();
    @(negedge wrClk); #0.5;
    prstN = 1'b0;
    repeat (3) @(posedge wrClk);
    repeat (2) @(posedge rdClk);
    @(negedge wrClk); #0.5;
    expQ.delete(); pendStd = 1'b0; pushCount = 0;
    prstN = 1'b1;
    settle();
  endtask

  initial begin : watchdog
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    logic [WIDTH-1:0] w;

    // ===== Phase A: standard mode, ae=2, af=3 =====
    mreset(1'b0, 2, 3);
    check(emptyOr === 1'b1,     "R1", "emptyOr after reset",     64'(emptyOr), 1);
    check(fullIr === 1'b0,      "R1", "fullIr after reset",      64'(fullIr), 0);
    check(almostEmpty === 1'b1, "R1", "almostEmpty after reset", 64'(almostEmpty), 1);
    check(almostFull === 1'b0,  "R1", "almostFull after reset",  64'(almostFull), 0);
    check(rdData === '0,        "R1", "rdData after reset",      64'(rdData), 0);

    // read from empty is ignored (R7)
    readWords(1);
    settle();
    check(rdData === '0 && emptyOr === 1'b1, "R7", "read on empty ignored", 64'(rdData), 0);

    // write into empty: empty clears at the third read edge (R11)
    @(posedge wrClk); #0.5;
    wrEn = 1'b1; wrData = mkWord(seed); seed++;
    @(posedge wrClk); #0.5;
    wrEn = 1'b0;
    repeat (2) @(posedge rdClk);
    @(negedge rdClk);
    check(emptyOr === 1'b1, "R11", "empty two read edges after write", 64'(emptyOr), 1);
    @(posedge rdClk); @(negedge rdClk);
    check(emptyOr === 1'b0, "R11", "empty three read edges after write", 64'(emptyOr), 0);
    settle();
    check(rdData === '0, "R4", "no fall-through in standard mode", 64'(rdData), 0);

    writeWords(1);  // 2 stored
    settle();
    check(almostEmpty === 1'b1, "R8", "ae at count 2 offset 2", 64'(almostEmpty), 1);
    writeWords(1);  // 3 stored
    settle();
    check(almostEmpty === 1'b0, "R8", "ae at count 3 offset 2", 64'(almostEmpty), 0);

    writeWords(9);  // 12 stored, 4 free
    settle();
    check(almostFull === 1'b0, "R9", "af with 4 free offset 3", 64'(almostFull), 0);
    writeWords(1);  // 13 stored, 3 free
    settle();
    check(almostFull === 1'b1, "R9", "af with 3 free offset 3", 64'(almostFull), 1);

    writeWords(3);  // full
    settle();
    check(fullIr === 1'b1, "R6", "full flag in standard mode", 64'(fullIr), 1);
    writeWords(2);  // ignored
    settle();
    check(pushCount == DEPTH, "R7", "writes accepted while full", 64'(pushCount), 64'(DEPTH));

    // read from full: full clears at the third write edge (R11)
    @(posedge rdClk); #0.5;
    rdEn = 1'b1;
    @(posedge rdClk); #0.5;
    rdEn = 1'b0;
    repeat (2) @(posedge wrClk);
    @(negedge wrClk);
    check(fullIr === 1'b1, "R11", "full two write edges after read", 64'(fullIr), 1);
    @(posedge wrClk); @(negedge wrClk);
    check(fullIr === 1'b0, "R11", "full three write edges after read", 64'(fullIr), 0);

    readWords(DEPTH + 1);
    settle();
    check(emptyOr === 1'b1, "R10", "empty after draining", 64'(emptyOr), 1);
    check(expQ.size() == 0, "R10", "all written words read", 64'(expQ.size()), 0);

    // ===== Phase B: fall-through mode, ae=1, af=5 =====
    mreset(1'b1, 1, 5);
    check(emptyOr === 1'b0,     "R1", "output-ready after reset", 64'(emptyOr), 0);
    check(fullIr === 1'b1,      "R1", "input-ready after reset",  64'(fullIr), 1);
    check(almostEmpty === 1'b1, "R1", "ae after fwft reset",      64'(almostEmpty), 1);

    readWords(1);   // not ready: ignored
    writeWords(1);
    settle();
    w = expQ.size() > 0 ? expQ[0] : '0;
    check(emptyOr === 1'b1, "R5", "word falls through", 64'(emptyOr), 1);
    check(rdData === w,     "R5", "fall-through data", 64'(rdData), 64'(w));
    check(almostEmpty === 1'b1, "R8", "ae counts output word", 64'(almostEmpty), 1);
    writeWords(1);
    settle();
    check(rdData === w, "R5", "later word waits for read", 64'(rdData), 64'(w));
    check(almostEmpty === 1'b0, "R8", "ae at count 2 offset 1", 64'(almostEmpty), 0);

    preset();
    check(emptyOr === 1'b0 && fullIr === 1'b1, "R3", "flush clears fwft flags",
          64'({emptyOr, fullIr}), 64'b01);
    check(almostEmpty === 1'b1 && rdData === '0, "R3", "flush empties output",
          64'(rdData), 0);

    // mode kept: word falls through, output-ready at the fourth read edge (R11)
    @(posedge wrClk); #0.5;
    wrEn = 1'b1; wrData = mkWord(seed); w = wrData; seed++;
    @(posedge wrClk); #0.5;
    wrEn = 1'b0;
    repeat (3) @(posedge rdClk);
    @(negedge rdClk);
    check(emptyOr === 1'b0, "R11", "output-ready three read edges after write", 64'(emptyOr), 0);
    @(posedge rdClk); @(negedge rdClk);
    check(emptyOr === 1'b1, "R11", "output-ready four read edges after write", 64'(emptyOr), 1);
    check(rdData === w, "R3", "mode kept through flush", 64'(rdData), 64'(w));
    settle();
    check(almostEmpty === 1'b1, "R3", "ae offset kept through flush", 64'(almostEmpty), 1);
    writeWords(1);
    settle();
    check(almostEmpty === 1'b0, "R3", "ae offset 1 at count 2", 64'(almostEmpty), 0);

    writeWords(DEPTH + 3);
    settle();
    check(fullIr === 1'b0, "R6", "input-ready low when full", 64'(fullIr), 0);
    check(pushCount == DEPTH + 1, "R10", "fwft capacity", 64'(pushCount), 64'(DEPTH + 1));
    check(almostFull === 1'b1, "R9", "af when memory full", 64'(almostFull), 1);

    readWords(DEPTH + 3);
    settle();
    check(emptyOr === 1'b0, "R10", "output-ready low after drain", 64'(emptyOr), 0);
    check(expQ.size() == 0, "R10", "fwft words all read", 64'(expQ.size()), 0);

    // ===== Phase C: master reset reloads standard mode (R2) =====
    mreset(1'b0, 2, 3);
    check(emptyOr === 1'b1 && fullIr === 1'b0, "R2", "standard polarity reloaded",
          64'({emptyOr, fullIr}), 64'b10);
    writeWords(1);
    settle();
    check(emptyOr === 1'b0 && rdData === '0, "R2", "standard mode reloaded, no fall-through",
          64'(rdData), 0);
    readWords(1);
    settle();
    check(expQ.size() == 0, "R4", "standard read delivered", 64'(expQ.size()), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule